// File: doc/BRIEF.md
# Dual-Clock Two-Port Synchronous Memory

This block is a synchronous memory with two access ports, A and B. Each port has its own clock, enable, write enable, address, write data and read data. The two ports share nothing but the stored words. Every access is taken at the rising edge of the port's own clock. Write data, address, enable and write enable are sampled at that edge, and read data leaves a register.

Each port is configured on its own. The configuration covers whether a second output register is inserted, what the port shows while it writes, and whether its address is held between enabled operations. A build-time split option turns the array into two independent memories of half the depth. Each half has its own pair of A/B ports, and the top address bit is dropped from every port.

Top module: `tdp_ram`

## Requirements
- R1: A word written through one port is returned by a later read of the same address through the other port.
- R2: Without the output register, read data appears at the port output one clock edge after the address is sampled with the enable high.
- R3: With the output register enabled, read data appears two edges after sampling, and after the first edge the output still shows the previous read result.
- R4: A port in old-data write mode (`WM_OLD`) outputs the contents the written address held before the write.
- R5: A port in new-data write mode (`WM_NEW`) outputs the data it is writing.
- R6: A port in hold write mode (`WM_HOLD`) keeps its output unchanged across the write.
- R7: With address holding on and the enable low, nothing is written even if the write enable is high, and the output keeps its value.
- R8: With address holding off, the port reads the presented address at every edge whatever the enable, and a write still needs the enable high.
- R9: When both ports share one clock and write the same address at the same edge, the word keeps port A's data.
- R10: With `SPLIT=1`, half h (bit h of each port vector) owns its own set of words, so equal addresses in the two halves hold different data. With `SPLIT=0`, all `ADDR_W` address bits select distinct words.
- R11: While `rst_ni` is low, every read output and output register is zero. The stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the output registers |
| en_a_i | input | SPLIT+1 | Port A enable, one bit per half |
| we_a_i | input | SPLIT+1 | Port A write enable, one bit per half |
| addr_a_i | input | (SPLIT+1) x (ADDR_W-SPLIT) | Port A word address per half |
| din_a_i | input | (SPLIT+1) x DATA_W | Port A write data per half |
| dout_a_o | output | (SPLIT+1) x DATA_W | Port A read data per half |
| en_b_i | input | SPLIT+1 | Port B enable, one bit per half |
| we_b_i | input | SPLIT+1 | Port B write enable, one bit per half |
| addr_b_i | input | (SPLIT+1) x (ADDR_W-SPLIT) | Port B word address per half |
| din_b_i | input | (SPLIT+1) x DATA_W | Port B write data per half |
| dout_b_o | output | (SPLIT+1) x DATA_W | Port B read data per half |

## Verification
Two things can fall on the same edge: a write from port A and a write from port B to one word. Both ports run from a common clock, and the bench drives equal addresses with different data on the same edge. It then reads the word back through port A and expects port A's data.

A second coincidence is a write combined with the port's own read-out. The bench judges this per write mode by what the writing port outputs on the next edge: the old word, the new data, or its unchanged earlier value.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
  typedef enum logic [1:0] {
    WM_OLD  = 2'd0,
    WM_NEW  = 2'd1,
    WM_HOLD = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/tdp_ram_bank.sv
// Storage shared by two clocks: each port owns one array, word = xor of both.
module tdp_ram_bank #(
  parameter int DATA_W = 8,
  parameter int AW     = 6
) (
  input  logic              clk_a_i,
  input  logic              en_a_i,
  input  logic              we_a_i,
  input  logic [AW-1:0]     addr_a_i,
  input  logic [DATA_W-1:0] din_a_i,
  output logic [DATA_W-1:0] rd_a_o,
  input  logic              clk_b_i,
  input  logic              en_b_i,
  input  logic              we_b_i,
  input  logic [AW-1:0]     addr_b_i,
  input  logic [DATA_W-1:0] din_b_i,
  output logic [DATA_W-1:0] rd_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_a [DEPTH];
  logic [DATA_W-1:0] mem_b [DEPTH];
  logic wr_a, wr_b;

  assign wr_a = en_a_i & we_a_i;
  // port A has priority on a same-edge, same-word write
  assign wr_b = en_b_i & we_b_i & ~(wr_a && (addr_a_i == addr_b_i));

  always_ff @(posedge clk_a_i) begin
    if (wr_a) mem_a[addr_a_i] <= din_a_i ^ mem_b[addr_a_i];
  end

  always_ff @(posedge clk_b_i) begin
    if (wr_b) mem_b[addr_b_i] <= din_b_i ^ mem_a[addr_b_i];
  end

  assign rd_a_o = mem_a[addr_a_i] ^ mem_b[addr_a_i];
  assign rd_b_o = mem_a[addr_b_i] ^ mem_b[addr_b_i];
endmodule

// File: rtl/tdp_ram_port.sv
module tdp_ram_port
  import tdp_ram_pkg::*;
#(
  parameter int       DATA_W     = 8,
  parameter wr_mode_e WMODE      = WM_OLD,
  parameter bit       OUT_REG    = 1'b0,
  parameter bit       ADDR_LATCH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DATA_W-1:0] mem_rd_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] rd_q;
  logic              rd_en;

  assign rd_en = en_i | ~ADDR_LATCH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (en_i && we_i) begin
      case (WMODE)
        WM_OLD:  rd_q <= mem_rd_i;
        WM_NEW:  rd_q <= din_i;
        default: rd_q <= rd_q;
      endcase
    end else if (rd_en) begin
      rd_q <= mem_rd_i;
    end
  end

  generate
    if (OUT_REG) begin : g_pipe
      logic [DATA_W-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= rd_q;
      end
      assign dout_o = pipe_q;

      p_pipe_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dout_o == $past(rd_q));
    end else begin : g_direct
      assign dout_o = rd_q;
    end

    if (WMODE == WM_NEW) begin : g_a_new
      p_write_new_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && we_i |=> rd_q == $past(din_i));
    end
    if (WMODE == WM_HOLD) begin : g_a_hold
      p_write_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && we_i |=> $stable(rd_q));
    end
    if (ADDR_LATCH) begin : g_a_latch
      p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(rd_q));
    end
  endgenerate

  p_reset_zero_r11: assert property (@(posedge clk_i)
    !rst_ni |-> dout_o == '0);
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
  import tdp_ram_pkg::*;
#(
  parameter int       DATA_W       = 8,
  parameter int       ADDR_W       = 6,
  parameter int       SPLIT        = 0,
  parameter bit       OUT_REG_A    = 1'b0,
  parameter bit       OUT_REG_B    = 1'b0,
  parameter wr_mode_e WMODE_A      = WM_OLD,
  parameter wr_mode_e WMODE_B      = WM_OLD,
  parameter bit       ADDR_LATCH_A = 1'b1,
  parameter bit       ADDR_LATCH_B = 1'b1
) (
  input  logic                                 clk_a_i,
  input  logic                                 clk_b_i,
  input  logic                                 rst_ni,
  input  logic [SPLIT:0]                       en_a_i,
  input  logic [SPLIT:0]                       we_a_i,
  input  logic [SPLIT:0][ADDR_W-SPLIT-1:0]     addr_a_i,
  input  logic [SPLIT:0][DATA_W-1:0]           din_a_i,
  output logic [SPLIT:0][DATA_W-1:0]           dout_a_o,
  input  logic [SPLIT:0]                       en_b_i,
  input  logic [SPLIT:0]                       we_b_i,
  input  logic [SPLIT:0][ADDR_W-SPLIT-1:0]     addr_b_i,
  input  logic [SPLIT:0][DATA_W-1:0]           din_b_i,
  output logic [SPLIT:0][DATA_W-1:0]           dout_b_o
);
  localparam int NB      = SPLIT + 1;
  localparam int BANK_AW = ADDR_W - SPLIT;

  initial begin
    assert (SPLIT == 0 || SPLIT == 1) else $error("SPLIT must be 0 or 1");
  end

  for (genvar h = 0; h < NB; h++) begin : g_half
    logic [DATA_W-1:0] rd_a, rd_b;

    tdp_ram_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) i_bank (
      .clk_a_i (clk_a_i),
      .en_a_i  (en_a_i[h]),
      .we_a_i  (we_a_i[h]),
      .addr_a_i(addr_a_i[h]),
      .din_a_i (din_a_i[h]),
      .rd_a_o  (rd_a),
      .clk_b_i (clk_b_i),
      .en_b_i  (en_b_i[h]),
      .we_b_i  (we_b_i[h]),
      .addr_b_i(addr_b_i[h]),
      .din_b_i (din_b_i[h]),
      .rd_b_o  (rd_b)
    );

    tdp_ram_port #(
      .DATA_W(DATA_W), .WMODE(WMODE_A), .OUT_REG(OUT_REG_A), .ADDR_LATCH(ADDR_LATCH_A)
    ) i_port_a (
      .clk_i   (clk_a_i),
      .rst_ni  (rst_ni),
      .en_i    (en_a_i[h]),
      .we_i    (we_a_i[h]),
      .din_i   (din_a_i[h]),
      .mem_rd_i(rd_a),
      .dout_o  (dout_a_o[h])
    );

    tdp_ram_port #(
      .DATA_W(DATA_W), .WMODE(WMODE_B), .OUT_REG(OUT_REG_B), .ADDR_LATCH(ADDR_LATCH_B)
    ) i_port_b (
      .clk_i   (clk_b_i),
      .rst_ni  (rst_ni),
      .en_i    (en_b_i[h]),
      .we_i    (we_b_i[h]),
      .din_i   (din_b_i[h]),
      .mem_rd_i(rd_b),
      .dout_o  (dout_b_o[h])
    );
  end
endmodule

// File: tb/test_tdp_ram.sv
`timescale 1ns/1ps
module test_tdp_ram;
  import tdp_ram_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int errs = 0;

  // split instance: 2 halves x 16 words
  logic [1:0]      s_en_a, s_we_a, s_en_b, s_we_b;
  logic [1:0][3:0] s_addr_a, s_addr_b;
  logic [1:0][7:0] s_din_a, s_din_b, s_dout_a, s_dout_b;
  // full instance: 32 words
  logic [0:0]      f_en_a, f_we_a, f_en_b, f_we_b;
  logic [0:0][4:0] f_addr_a, f_addr_b;
  logic [0:0][7:0] f_din_a, f_din_b, f_dout_a, f_dout_b;

  tdp_ram #(
    .DATA_W(8), .ADDR_W(5), .SPLIT(1),
    .OUT_REG_A(1'b0), .OUT_REG_B(1'b1),
    .WMODE_A(WM_OLD), .WMODE_B(WM_NEW),
    .ADDR_LATCH_A(1'b1), .ADDR_LATCH_B(1'b1)
  ) i_tdp_ram (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .en_a_i(s_en_a), .we_a_i(s_we_a), .addr_a_i(s_addr_a), .din_a_i(s_din_a), .dout_a_o(s_dout_a),
    .en_b_i(s_en_b), .we_b_i(s_we_b), .addr_b_i(s_addr_b), .din_b_i(s_din_b), .dout_b_o(s_dout_b)
  );

  tdp_ram #(
    .DATA_W(8), .ADDR_W(5), .SPLIT(0),
    .OUT_REG_A(1'b0), .OUT_REG_B(1'b0),
    .WMODE_A(WM_HOLD), .WMODE_B(WM_OLD),
    .ADDR_LATCH_A(1'b1), .ADDR_LATCH_B(1'b0)
  ) i_tdp_ram_full (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .en_a_i(f_en_a), .we_a_i(f_we_a), .addr_a_i(f_addr_a), .din_a_i(f_din_a), .dout_a_o(f_dout_a),
    .en_b_i(f_en_b), .we_b_i(f_we_b), .addr_b_i(f_addr_b), .din_b_i(f_din_b), .dout_b_o(f_dout_b)
  );

  function automatic logic [7:0] val(int h, int a);
    return 8'(((h * 16 + a) * 37) + 11);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    s_en_a = '0; s_we_a = '0; s_en_b = '0; s_we_b = '0;
    f_en_a = '0; f_we_a = '0; f_en_b = '0; f_we_b = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    idle();
    s_addr_a = '0; s_addr_b = '0; s_din_a = '0; s_din_b = '0;
    f_addr_a = '0; f_addr_b = '0; f_din_a = '0; f_din_b = '0;
    repeat (3) step();
    // R11 reset state
    for (int h = 0; h < 2; h++) begin
      chk("R11 split A", s_dout_a[h], 8'h00);
      chk("R11 split B", s_dout_b[h], 8'h00);
    end
    chk("R11 full A", f_dout_a[0], 8'h00);
    rst_n = 1'b1;
    step();

    // fill both halves through port A
    for (int a = 0; a < 16; a++) begin
      s_en_a = 2'b11; s_we_a = 2'b11;
      for (int h = 0; h < 2; h++) begin
        s_addr_a[h] = 4'(a); s_din_a[h] = val(h, a);
      end
      step();
    end
    idle();

    // sweep: A reads a, B reads 15-a (B has the output register)
    for (int a = 0; a < 16; a++) begin
      s_en_a = 2'b11; s_en_b = 2'b11;
      for (int h = 0; h < 2; h++) begin
        s_addr_a[h] = 4'(a); s_addr_b[h] = 4'(15 - a);
      end
      step();
      for (int h = 0; h < 2; h++) begin
        chk("R2 R10 A read", s_dout_a[h], val(h, a));
        chk("R3 B not yet", s_dout_b[h], (a == 0) ? 8'h00 : val(h, 16 - a));
      end
      step();
      for (int h = 0; h < 2; h++) chk("R1 R3 B read", s_dout_b[h], val(h, 15 - a));
    end
    idle();

    // R4: A old-data write, half 0
    s_en_a[0] = 1'b1; s_we_a[0] = 1'b1; s_addr_a[0] = 4'd5; s_din_a[0] = 8'hA5;
    step();
    chk("R4 old data", s_dout_a[0], val(0, 5));
    s_we_a[0] = 1'b0;
    step();
    chk("R4 stored", s_dout_a[0], 8'hA5);
    idle();

    // R5: B new-data write, half 1
    s_en_b[1] = 1'b1; s_we_b[1] = 1'b1; s_addr_b[1] = 4'd7; s_din_b[1] = 8'h5A;
    step();
    idle();
    step();
    chk("R5 new data", s_dout_b[1], 8'h5A);
    s_en_a[1] = 1'b1; s_addr_a[1] = 4'd7;
    step();
    chk("R1 A sees B write", s_dout_a[1], 8'h5A);
    idle();

    // R7: enable low, write enable high, half 0
    s_we_a[0] = 1'b1; s_addr_a[0] = 4'd2; s_din_a[0] = 8'hFF;
    step();
    chk("R7 output held", s_dout_a[0], 8'hA5);
    s_we_a[0] = 1'b0; s_en_a[0] = 1'b1;
    step();
    chk("R7 no write", s_dout_a[0], val(0, 2));
    idle();

    // R9: same-edge collision on half 0, word 9
    s_en_a[0] = 1'b1; s_we_a[0] = 1'b1; s_addr_a[0] = 4'd9; s_din_a[0] = 8'h11;
    s_en_b[0] = 1'b1; s_we_b[0] = 1'b1; s_addr_b[0] = 4'd9; s_din_b[0] = 8'h22;
    step();
    idle();
    s_en_a[0] = 1'b1;
    step();
    chk("R9 port A wins", s_dout_a[0], 8'h11);
    chk("R10 other half intact", s_dout_a[1], 8'h5A);
    idle();

    // full instance: A hold mode, B old-data with address holding off
    f_en_a = 1'b1; f_we_a = 1'b1; f_addr_a[0] = 5'd31; f_din_a[0] = 8'hC3;
    step();
    chk("R6 hold on write", f_dout_a[0], 8'h00);
    f_addr_a[0] = 5'd15; f_din_a[0] = 8'h3C;
    step();
    chk("R6 hold on 2nd write", f_dout_a[0], 8'h00);
    idle();
    f_addr_b[0] = 5'd31;
    step();
    chk("R8 read w/o enable", f_dout_b[0], 8'hC3);
    f_addr_b[0] = 5'd15;
    step();
    chk("R10 full upper bit", f_dout_b[0], 8'h3C);
    f_we_b = 1'b1; f_din_b[0] = 8'h99;
    step();
    chk("R8 no write w/o enable", f_dout_b[0], 8'h3C);
    f_we_b = 1'b0;
    step();
    chk("R8 word unchanged", f_dout_b[0], 8'h3C);
    f_en_a = 1'b1; f_addr_a[0] = 5'd31;
    step();
    chk("R2 full A read", f_dout_a[0], 8'hC3);
    idle();
    step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule